// File: doc/BRIEF.md
# 64-bit Paired-Register Compare-Exchange Unit

This unit carries out an atomic 64-bit compare-and-exchange against a 32-bit memory port. The caller supplies a base address and two register pairs. The expected pair (low and high halves) is what memory should hold. The replacement pair is what memory gets if it does. The unit first fetches the low word from the base address and then the high word from the next word address. A single match decision covers both halves. On a match the replacement pair is stored to the same two locations. On a mismatch the fetched pair is handed back to be written into the expected registers. The only flag produced is a zero flag.

The bus lock stays asserted from the first access until completion, so no other agent can slip in between the reads and the writes. A fault on any of the four accesses stops the operation. In that case nothing is written back to registers and the flag is left alone. With the completion pulse the unit also reports a cycle cost, which depends on whether the instruction used the register or the memory operand form.

Top module: `cx64_unit`

## Requirements
- R1: After a start is accepted, the first access is a read of the base address and the second is a read of base address + 4. No write occurs before both reads have completed.
- R2: A match is declared only when the word at the base equals `exp_lo` and the word at base + 4 equals `exp_hi`. A difference in either half alone gives a mismatch.
- R3: On a match, `rep_lo` is written to the base address, and after that `rep_hi` is written to base + 4. No write is issued on a mismatch.
- R4: On a mismatch without fault, `wb_en` pulses with `done`, and `wb_lo`/`wb_hi` carry the words read from base and base + 4.
- R5: On a completion without fault, `zf_we` pulses with `done`, and `zf` is 1 for a match and 0 for a mismatch. No other flag is produced.
- R6: `cost` is valid with `done`. It is 6 when `mem_mode` was 0 (register form) at start and 10 when it was 1 (memory form).
- R7: A fault on any access ends the operation. `done` and `done_fault` pulse together, `wb_en` and `zf_we` stay 0, and no further access is issued. Writes that completed before a fault on the high write stay in memory.
- R8: `mem_lock` is high from the first access through the `done` cycle. Every cycle with `mem_req` high also has `mem_lock` high.
- R9: `done` is high for exactly one cycle per accepted start. A `start` seen while the unit is busy, including during the `done` cycle, is ignored.
- R10: When `mem_fault` and `mem_ack` are both high in the same cycle, the access counts as faulted. A write is then not treated as completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| mem_mode | input | 1 | Operand form: 0 register, 1 memory (selects cost) |
| base_addr | input | ADDR_W | Byte address of the low word |
| exp_lo | input | DATA_W | Expected value, low half |
| exp_hi | input | DATA_W | Expected value, high half |
| rep_lo | input | DATA_W | Replacement value, low half |
| rep_hi | input | DATA_W | Replacement value, high half |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_fault | input | 1 | Access faulted |
| mem_lock | output | 1 | Bus lock held over the sequence |
| wb_en | output | 1 | Load `wb_lo`/`wb_hi` into the expected registers |
| wb_lo | output | DATA_W | Memory low word for write-back |
| wb_hi | output | DATA_W | Memory high word for write-back |
| zf_we | output | 1 | Zero flag update strobe |
| zf | output | 1 | Zero flag value |
| done | output | 1 | Completion pulse |
| done_fault | output | 1 | Completion was caused by a fault |
| cost | output | COST_W | Reported cycle cost, valid with `done` |

## Verification
Two things can land on the same cycle. The first is a fresh `start` and the `done` pulse of the running operation. The bench drives `start` during the `done` cycle and also once in the middle of a sequence, then checks that no further access appears and that only one completion arrives for each pushed item. The second is `mem_ack` and `mem_fault` being raised together on the low write. The scoreboard expects a faulted completion, and the bench confirms that memory still holds its old words.

// File: rtl/cx64_pkg.sv
package cx64_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD_LO = 3'd1,
      ST_RD_HI = 3'd2,
      ST_CMP   = 3'd3,
      ST_WR_LO = 3'd4,
      ST_WR_HI = 3'd5,
      ST_FIN   = 3'd6
   } cx_state_e;

   localparam int unsigned HALVES = 2;
endpackage

// File: rtl/cx64_cmp.sv
module cx64_cmp #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 2
) (
   input  logic [WORDS-1:0][DATA_W-1:0] mem_words,
   input  logic [WORDS-1:0][DATA_W-1:0] exp_words,
   output logic                         all_equal
);
   logic [WORDS-1:0] eq;

   for (genvar i = 0; i < WORDS; i++) begin : g_half
      assign eq[i] = (mem_words[i] == exp_words[i]);
   end

   assign all_equal = &eq;
endmodule

// File: rtl/cx64_seq.sv
module cx64_seq
   import cx64_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      accept,
   input  logic      acc_ok,
   input  logic      acc_bad,
   input  logic      match_now,
   output cx_state_e state
);
   cx_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (accept) nxt = ST_RD_LO;
         ST_RD_LO: if (acc_bad) nxt = ST_FIN; else if (acc_ok) nxt = ST_RD_HI;
         ST_RD_HI: if (acc_bad) nxt = ST_FIN; else if (acc_ok) nxt = ST_CMP;
         ST_CMP:   nxt = match_now ? ST_WR_LO : ST_FIN;
         ST_WR_LO: if (acc_bad) nxt = ST_FIN; else if (acc_ok) nxt = ST_WR_HI;
         ST_WR_HI: if (acc_bad || acc_ok) nxt = ST_FIN;
         ST_FIN:   nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R9: completion lasts one cycle, then the unit is idle again
   assert_fin_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIN) |=> (state == ST_IDLE));
   // R7: a faulted access never leads to another access state
   assert_fault_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_bad |=> (state == ST_FIN));
endmodule

// File: rtl/cx64_unit.sv
module cx64_unit
   import cx64_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REG_COST = 6,
   parameter int unsigned MEM_COST = 10,
   localparam int unsigned COST_W  = $clog2(MEM_COST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mem_mode,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DATA_W-1:0] exp_lo,
   input  logic [DATA_W-1:0] exp_hi,
   input  logic [DATA_W-1:0] rep_lo,
   input  logic [DATA_W-1:0] rep_hi,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_fault,
   output logic              mem_lock,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_lo,
   output logic [DATA_W-1:0] wb_hi,
   output logic              zf_we,
   output logic              zf,
   output logic              done,
   output logic              done_fault,
   output logic [COST_W-1:0] cost
);
   localparam int unsigned WORD_BYTES = DATA_W / 8;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("cx64_unit: DATA_W must be a whole number of bytes");
   end
   if (REG_COST > MEM_COST) begin : g_bad_cost
      $error("cx64_unit: REG_COST must not exceed MEM_COST");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("cx64_unit: ADDR_W too small");
   end

   cx_state_e state;

   logic [ADDR_W-1:0]               base_q;
   logic [HALVES-1:0][DATA_W-1:0]   exp_q;
   logic [HALVES-1:0][DATA_W-1:0]   rep_q;
   logic [HALVES-1:0][DATA_W-1:0]   rd_q;
   logic                            mode_q;
   logic                            match_q;
   logic                            flt_q;
   logic                            match_now;
   logic                            accept;
   logic                            acc_ok;
   logic                            acc_bad;
   logic                            hi_phase;

   assign accept  = start && (state == ST_IDLE);
   assign acc_bad = mem_req && mem_fault;
   assign acc_ok  = mem_req && mem_ack && !mem_fault;

   cx64_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_ok    (acc_ok),
      .acc_bad   (acc_bad),
      .match_now (match_now),
      .state     (state)
   );

   cx64_cmp #(.DATA_W(DATA_W), .WORDS(HALVES)) u_cmp (
      .mem_words (rd_q),
      .exp_words (exp_q),
      .all_equal (match_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         exp_q   <= '0;
         rep_q   <= '0;
         rd_q    <= '0;
         mode_q  <= 1'b0;
         match_q <= 1'b0;
         flt_q   <= 1'b0;
      end else begin
         if (accept) begin
            base_q  <= base_addr;
            exp_q   <= {exp_hi, exp_lo};
            rep_q   <= {rep_hi, rep_lo};
            mode_q  <= mem_mode;
            match_q <= 1'b0;
            flt_q   <= 1'b0;
         end
         if (acc_bad) flt_q <= 1'b1;
         if (acc_ok && state == ST_RD_LO) rd_q[0] <= mem_rdata;
         if (acc_ok && state == ST_RD_HI) rd_q[1] <= mem_rdata;
         if (state == ST_CMP) match_q <= match_now;
      end
   end

   assign hi_phase  = (state == ST_RD_HI) || (state == ST_WR_HI);
   assign mem_req   = (state == ST_RD_LO) || (state == ST_RD_HI) ||
                      (state == ST_WR_LO) || (state == ST_WR_HI);
   assign mem_we    = (state == ST_WR_LO) || (state == ST_WR_HI);
   assign mem_addr  = hi_phase ? base_q + ADDR_W'(WORD_BYTES) : base_q;
   assign mem_wdata = hi_phase ? rep_q[1] : rep_q[0];
   assign mem_lock  = (state != ST_IDLE);

   assign done       = (state == ST_FIN);
   assign done_fault = done && flt_q;
   assign zf_we      = done && !flt_q;
   assign zf         = match_q;
   assign wb_en      = zf_we && !match_q;
   assign wb_lo      = rd_q[0];
   assign wb_hi      = rd_q[1];
   assign cost       = mode_q ? COST_W'(MEM_COST) : COST_W'(REG_COST);

   // R1: the sequence opens with a read of the base address
   assert_first_read_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_lock) |-> (mem_req && !mem_we && mem_addr == base_q));
   // R3: a store is only ever issued after a full match
   assert_write_after_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> match_q);
   // R4: register write-back only on a clean mismatch
   assert_wb_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (zf_we && !zf && !done_fault));
   // R7: a fault suppresses flag and register updates
   assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_fault |-> (!zf_we && !wb_en));
   // R7, R10: no access follows a faulted one
   assert_no_access_after_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_bad |=> !mem_req);
   // R8: the lock covers every access
   assert_req_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);
   // R9: done is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: captured operands are untouched while busy
   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> ($stable(base_q) && $stable(mode_q) && $stable(rep_q)));
endmodule

// File: tb/cx64_unit_tb.sv
module cx64_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mem_mode = 1'b0;
   logic [31:0] base_addr = '0, exp_lo = '0, exp_hi = '0, rep_lo = '0, rep_hi = '0;
   logic        mem_req, mem_we, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0, mem_fault = 1'b0;
   logic        wb_en, zf_we, zf, done, done_fault;
   logic [31:0] wb_lo, wb_hi;
   logic [3:0]  cost;

   always #10 clk = ~clk;

   cx64_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_mode(mem_mode),
      .base_addr(base_addr), .exp_lo(exp_lo), .exp_hi(exp_hi),
      .rep_lo(rep_lo), .rep_hi(rep_hi),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .mem_fault(mem_fault), .mem_lock(mem_lock),
      .wb_en(wb_en), .wb_lo(wb_lo), .wb_hi(wb_hi), .zf_we(zf_we), .zf(zf),
      .done(done), .done_fault(done_fault), .cost(cost)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model with fault injection
   logic [31:0] mem [16];
   logic [31:0] flt_addr = '0;
   bit          flt_en = 0, flt_we = 0, flt_both = 0;
   int          n_acc = 0;
   logic [31:0] log_addr [4];
   logic        log_we [4];

   always @(negedge clk) begin
      mem_ack   = 1'b0;
      mem_fault = 1'b0;
      if (mem_req) begin
         if (n_acc < 4) begin
            log_addr[n_acc] = mem_addr;
            log_we[n_acc]   = mem_we;
         end
         n_acc++;
         if (flt_en && mem_addr == flt_addr && mem_we == flt_we) begin
            mem_fault = 1'b1;
            mem_ack   = flt_both;
         end else begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[5:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[5:2]];
         end
      end
   end

   typedef struct packed {
      logic             flt;
      logic             wb;
      logic [31:0]      lo;
      logic [31:0]      hi;
      logic             zw;
      logic             z;
      logic [3:0]       cost;
      logic [2:0]       n;
      logic [3:0][31:0] a;
      logic [3:0]       w;
   } exp_t;

   exp_t sb_q[$];

   // monitor: pops one item per completion
   always @(negedge clk) begin
      if (rst_n && mem_req && !mem_lock)
         chk(1'b0, "R8 lock during access", {31'd0, mem_lock}, 32'd1);
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(done_fault == e.flt, "R7 done_fault", {31'd0, done_fault}, {31'd0, e.flt});
            chk(wb_en == e.wb, "R4 wb_en", {31'd0, wb_en}, {31'd0, e.wb});
            if (e.wb) begin
               chk(wb_lo == e.lo, "R4 wb_lo", wb_lo, e.lo);
               chk(wb_hi == e.hi, "R4 wb_hi", wb_hi, e.hi);
            end
            chk(zf_we == e.zw, "R5 zf_we", {31'd0, zf_we}, {31'd0, e.zw});
            if (e.zw) chk(zf == e.z, "R5/R2 zf", {31'd0, zf}, {31'd0, e.z});
            chk(cost == e.cost, "R6 cost", {28'd0, cost}, {28'd0, e.cost});
            chk(n_acc == int'(e.n), "R1/R3 access count", n_acc, {29'd0, e.n});
            for (int i = 0; i < 4; i++) begin
               if (i < int'(e.n) && i < n_acc) begin
                  chk(log_addr[i] == e.a[i], "R1/R3 access address", log_addr[i], e.a[i]);
                  chk(log_we[i] == e.w[i], "R1/R3 access direction",
                      {31'd0, log_we[i]}, {31'd0, e.w[i]});
               end
            end
         end
      end
   end

   task automatic run_op(input logic [31:0] b, input logic [31:0] elo, ehi, rlo, rhi,
                         input bit mode, input bit fen, input logic [31:0] fa,
                         input bit fwe, input bit fboth, input bit poke);
      exp_t e;
      logic [31:0] mlo, mhi, new_lo, new_hi;
      bit match;
      int k;
      mlo   = mem[b[5:2]];
      mhi   = mem[b[5:2] + 4'd1];
      match = (mlo == elo) && (mhi == ehi);
      e.a   = {b + 32'd4, b, b + 32'd4, b};
      e.w   = 4'b1100;
      k     = match ? 4 : 2;
      for (int i = k - 1; i >= 0; i--)
         if (fen && e.a[i] == fa && e.w[i] == fwe) k = i + 1;
      e.flt = fen && (k < (match ? 4 : 2) ||
                      (e.a[k-1] == fa && e.w[k-1] == fwe));
      e.n   = 3'(k);
      e.wb  = !e.flt && !match;
      e.lo  = mlo;
      e.hi  = mhi;
      e.zw  = !e.flt;
      e.z   = match;
      e.cost = mode ? 4'd10 : 4'd6;
      new_lo = (match && (!e.flt || k > 3)) ? rlo : mlo;
      new_hi = (match && !e.flt) ? rhi : mhi;
      sb_q.push_back(e);

      flt_en = fen; flt_addr = fa; flt_we = fwe; flt_both = fboth;
      n_acc = 0;
      @(negedge clk);
      base_addr = b; exp_lo = elo; exp_hi = ehi; rep_lo = rlo; rep_hi = rhi;
      mem_mode = mode; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         base_addr = 32'h0000_0030; mem_mode = ~mode; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      start = 1'b1; base_addr = 32'h0000_0038;   // collides with done
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3; i++) @(negedge clk);
      chk(!mem_req && !mem_lock, "R9 start during done ignored", {31'd0, mem_req}, 32'd0);
      chk(mem[b[5:2]] == new_lo, "R3/R7 memory low word", mem[b[5:2]], new_lo);
      chk(mem[b[5:2] + 4'd1] == new_hi, "R3/R7 memory high word", mem[b[5:2] + 4'd1], new_hi);
      chk(sb_q.size() == 0, "R9 one done per start", sb_q.size(), 32'd0);
      flt_en = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + i;
      repeat (3) @(negedge clk);
      chk(!done && !mem_req && !mem_lock && !zf_we && !wb_en, "R8/R9 reset idle",
          {27'd0, done, mem_req, mem_lock, zf_we, wb_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 R3 R5 R6: full match, register form
      mem[2] = 32'h1111_2222; mem[3] = 32'h3333_4444;
      run_op(32'h08, 32'h1111_2222, 32'h3333_4444, 32'hDEAD_BEEF, 32'hCAFE_F00D,
             0, 0, 0, 0, 0, 0);
      // R2 R4: low half differs, memory form
      mem[4] = 32'h0000_0001; mem[5] = 32'h0000_0002;
      run_op(32'h10, 32'h0000_0009, 32'h0000_0002, 32'h5, 32'h6, 1, 0, 0, 0, 0, 0);
      // R2 R4: high half differs
      mem[6] = 32'h7777_0000; mem[7] = 32'h8888_0000;
      run_op(32'h18, 32'h7777_0000, 32'h8888_0001, 32'h1, 32'h2, 0, 0, 0, 0, 0, 0);
      // R9: match with a start poked mid-sequence
      mem[8] = 32'h0; mem[9] = 32'hFFFF_FFFF;
      run_op(32'h20, 32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 0, 0, 0, 1);
      // R7: fault on low read
      run_op(32'h28, mem[10], mem[11], 32'h1, 32'h2, 0, 1, 32'h28, 0, 0, 0);
      // R7: fault on high read
      run_op(32'h28, mem[10], mem[11], 32'h1, 32'h2, 1, 1, 32'h2C, 0, 0, 0);
      // R7: fault on high write, low write stays
      mem[12] = 32'h55; mem[13] = 32'h66;
      run_op(32'h30, 32'h55, 32'h66, 32'hAA, 32'hBB, 0, 1, 32'h34, 1, 0, 0);
      // R10: ack and fault together on low write
      mem[0] = 32'h99; mem[1] = 32'h98;
      run_op(32'h00, 32'h99, 32'h98, 32'h11, 32'h22, 1, 1, 32'h00, 1, 1, 0);
      // recovery after fault: plain match
      run_op(32'h00, 32'h99, 32'h98, 32'h11, 32'h22, 1, 0, 0, 0, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule